// File: doc/BRIEF.md
# Accumulator ALU with Flags

This unit performs the arithmetic and logic work of an 8-bit accumulator machine. Each operation takes an opcode byte, the current accumulator, a second operand byte and the current flags. The second operand has already been fetched by the surrounding machine, from a register, from memory or from the byte after the opcode. The unit produces a new accumulator and a new flag set. The operation is decoded straight from fixed opcode bit fields, so no translation table sits between the instruction byte and the datapath.

The unit handles eight operations that use two operands: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. It also handles four accumulator rotates, decimal adjust, complement accumulator, set carry and complement carry. The results pass through one register stage. That stage loads only when the valid strobe is high and the opcode is one the unit recognises. In all other cycles it holds its contents.

Flags are packed in a 5-bit vector as follows: bit 4 is sign, bit 3 is zero, bit 2 is auxiliary carry (the carry out of bit 3), bit 1 is parity and bit 0 is carry.

Top module: `acc_alu`

## Requirements
- R1: After reset, both `acc_out` and `flags_out` read zero.
- R2: When `valid` is high, the opcode is accepted and its result appears on `acc_out` and `flags_out` after the next rising clock edge. While `valid` is low, both outputs hold their values.
- R3: Opcodes of the form 10 ccc sss (register/memory forms) and 11 ccc 110 (immediate forms) select a two-operand operation from ccc, with `operand` as the second operand: 000 add, 001 add with carry, 010 subtract, 011 subtract with borrow, 100 AND, 101 XOR, 110 OR, 111 compare.
- R4: Add and add-with-carry write (A + B + cin) mod 256, where cin is 0 for add and flag bit 0 for add-with-carry. Carry is the carry out of bit 7 and auxiliary carry is the carry out of bit 3.
- R5: Subtract and subtract-with-borrow write (A - B - bin) mod 256, where bin is 0 for subtract and flag bit 0 for subtract-with-borrow. Carry is set when A < B + bin. Auxiliary carry is set when A[3:0] >= B[3:0] + bin.
- R6: AND, XOR and OR write the bitwise result and clear both carry and auxiliary carry.
- R7: Compare sets all five flags exactly as subtract would, but writes the unchanged input accumulator.
- R8: For every two-operand operation and for decimal adjust, sign is bit 7 of the result, zero is set for a zero result, and parity is set when the result has an even number of one bits. For compare, the result used is the difference.
- R9: Opcodes 0x07, 0x0F, 0x17 and 0x1F rotate the accumulator left, right, left through carry and right through carry. Carry receives the bit shifted out, and the other four flags pass through from `flags_in`.
- R10: Opcode 0x27 (decimal adjust) adds 0x06 when the low nibble exceeds 9 or auxiliary carry is set. It then adds 0x60 when carry is set, or when that first sum reaches 160 or more. Carry is set exactly when 0x60 was added, and auxiliary carry is the carry out of bit 3 from the first step.
- R11: Opcode 0x2F writes the bitwise complement of the accumulator and passes all flags through unchanged.
- R12: Opcode 0x37 sets carry and opcode 0x3F inverts carry. The accumulator passes through, and the other four flags pass through from `flags_in`.
- R13: Any opcode not covered by R3 and R9 to R12 leaves both outputs unchanged, even when `valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Strobe: load the result of `opcode` |
| opcode | input | 8 | Instruction byte |
| acc_in | input | 8 | Current accumulator |
| operand | input | 8 | Second operand, already fetched |
| flags_in | input | 5 | Current flags {S,Z,AC,P,CY} |
| acc_out | output | 8 | Registered new accumulator |
| flags_out | output | 5 | Registered new flags {S,Z,AC,P,CY} |

## Verification
A fault in decode or in the adder shows at the outputs one edge after the strobe, because only one register stands between the inputs and the outputs. Most errors appear as a wrong carry or auxiliary carry at an operand boundary such as 0x0F/0x10 or 0x7F/0x80. A compare that writes the accumulator shows in that same cycle. A missing hold on an unrecognised opcode shows as an output change where none is expected. Operand values are swept across all sixteen group opcodes, and every byte value is swept through the rotates and decimal adjust, so a single wrong nibble boundary cannot go unseen.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int FW = 5;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  typedef enum logic [2:0] {
    K_NONE, K_GROUP, K_ROT, K_DAA, K_CMA, K_STC, K_CMC
  } kind_t;

  typedef struct packed {
    kind_t      kind;
    logic [2:0] sel;
  } dec_t;

  localparam logic [2:0] OP_ADD = 3'b000;
  localparam logic [2:0] OP_ADC = 3'b001;
  localparam logic [2:0] OP_SUB = 3'b010;
  localparam logic [2:0] OP_SBB = 3'b011;
  localparam logic [2:0] OP_AND = 3'b100;
  localparam logic [2:0] OP_XOR = 3'b101;
  localparam logic [2:0] OP_OR  = 3'b110;
  localparam logic [2:0] OP_CMP = 3'b111;

  function automatic logic [DW:0] wide_add(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                           input logic ci);
    return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
  endfunction

  function automatic logic nib_carry(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                     input logic ci);
    logic [NW:0] n;
    n = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, ci};
    return n[NW];
  endfunction

  function automatic flags_t result_flags(input logic [DW-1:0] r, input logic ac,
                                          input logic cy);
    flags_t f;
    f.s  = r[DW-1];
    f.z  = (r == '0);
    f.ac = ac;
    f.p  = ~^r;
    f.cy = cy;
    return f;
  endfunction

  // returns {carry, aux carry, result}
  function automatic logic [DW+1:0] dec_adjust(input logic [DW-1:0] a, input logic ac_in,
                                               input logic cy_in);
    logic          lo;
    logic          hi;
    logic [NW:0]   nib;
    logic [DW:0]   t;
    logic [DW-1:0] r;
    lo  = (a[NW-1:0] > NW'(9)) || ac_in;
    nib = {1'b0, a[NW-1:0]} + (lo ? (NW+1)'(6) : '0);
    t   = {1'b0, a} + (lo ? (DW+1)'(6) : '0);
    hi  = cy_in || t[DW] || (t[DW-1:NW] > NW'(9));
    r   = t[DW-1:0] + (hi ? DW'(8'h60) : '0);
    return {hi, nib[NW], r};
  endfunction
endpackage

// File: rtl/acc_alu_decode.sv
`timescale 1ns/1ps
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] opcode,
  output dec_t          dec
);
  always_comb begin
    dec.kind = K_NONE;
    dec.sel  = opcode[5:3];
    if (opcode[7:6] == 2'b10) begin
      dec.kind = K_GROUP;
    end else if (opcode[7:6] == 2'b11 && opcode[2:0] == 3'b110) begin
      dec.kind = K_GROUP;
    end else if (opcode[7:6] == 2'b00 && opcode[2:0] == 3'b111) begin
      case (opcode[5:3])
        3'b100:  dec.kind = K_DAA;
        3'b101:  dec.kind = K_CMA;
        3'b110:  dec.kind = K_STC;
        3'b111:  dec.kind = K_CMC;
        default: dec.kind = K_ROT;
      endcase
    end
  end
endmodule

// File: rtl/acc_alu_group.sv
`timescale 1ns/1ps
module acc_alu_group
  import acc_alu_pkg::*;
(
  input  logic [2:0]    sel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cy,
  output logic          ac
);
  logic          is_sub;
  logic          is_logic;
  logic          ci;
  logic [DW-1:0] bx;
  logic [DW:0]   sum;

  always_comb begin
    is_sub   = (sel == OP_SUB) || (sel == OP_SBB) || (sel == OP_CMP);
    is_logic = sel[2] && (sel != OP_CMP);
    bx       = is_sub ? ~b : b;
    case (sel)
      OP_ADC:         ci = cin;
      OP_SUB, OP_CMP: ci = 1'b1;
      OP_SBB:         ci = ~cin;
      default:        ci = 1'b0;
    endcase
    sum = wide_add(a, bx, ci);
    case (sel)
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      OP_OR:   res = a | b;
      default: res = sum[DW-1:0];
    endcase
    cy = is_logic ? 1'b0 : (is_sub ? ~sum[DW] : sum[DW]);
    ac = is_logic ? 1'b0 : nib_carry(a, bx, ci);
  end
endmodule

// File: rtl/acc_alu_misc.sv
`timescale 1ns/1ps
module acc_alu_misc
  import acc_alu_pkg::*;
(
  input  kind_t         kind,
  input  logic [1:0]    rsel,
  input  logic [DW-1:0] a,
  input  flags_t        fin,
  output logic [DW-1:0] res,
  output flags_t        fout
);
  logic [DW+1:0] adj;

  always_comb begin
    res  = a;
    fout = fin;
    adj  = dec_adjust(a, fin.ac, fin.cy);
    case (kind)
      K_ROT: begin
        case (rsel)
          2'd0: begin res = {a[DW-2:0], a[DW-1]}; fout.cy = a[DW-1]; end
          2'd1: begin res = {a[0], a[DW-1:1]};    fout.cy = a[0];    end
          2'd2: begin res = {a[DW-2:0], fin.cy};  fout.cy = a[DW-1]; end
          default: begin res = {fin.cy, a[DW-1:1]}; fout.cy = a[0]; end
        endcase
      end
      K_DAA: begin
        res  = adj[DW-1:0];
        fout = result_flags(adj[DW-1:0], adj[DW], adj[DW+1]);
      end
      K_CMA: res = ~a;
      K_STC: fout.cy = 1'b1;
      K_CMC: fout.cy = ~fin.cy;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [DW-1:0] opcode,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] operand,
  input  logic [FW-1:0] flags_in,
  output logic [DW-1:0] acc_out,
  output logic [FW-1:0] flags_out
);
  dec_t          dec;
  flags_t        fin;
  logic [DW-1:0] g_res;
  logic          g_cy;
  logic          g_ac;
  logic [DW-1:0] m_res;
  flags_t        m_flg;
  logic [DW-1:0] nxt_acc;
  flags_t        nxt_flg;
  logic [DW-1:0] acc_q;
  flags_t        flg_q;
  logic          upd;

  assign fin = flags_t'(flags_in);

  acc_alu_decode u_dec (.opcode(opcode), .dec(dec));

  acc_alu_group u_grp (
    .sel(dec.sel), .a(acc_in), .b(operand), .cin(fin.cy),
    .res(g_res), .cy(g_cy), .ac(g_ac)
  );

  acc_alu_misc u_misc (
    .kind(dec.kind), .rsel(dec.sel[1:0]), .a(acc_in), .fin(fin),
    .res(m_res), .fout(m_flg)
  );

  always_comb begin
    case (dec.kind)
      K_GROUP: begin
        nxt_acc = (dec.sel == OP_CMP) ? acc_in : g_res;
        nxt_flg = result_flags(g_res, g_ac, g_cy);
      end
      K_NONE: begin
        nxt_acc = acc_q;
        nxt_flg = flg_q;
      end
      default: begin
        nxt_acc = m_res;
        nxt_flg = m_flg;
      end
    endcase
  end

  assign upd = valid && (dec.kind != K_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (upd) begin
      acc_q <= nxt_acc;
      flg_q <= nxt_flg;
    end
  end

  assign acc_out   = acc_q;
  assign flags_out = flg_q;

  // named events for the checks below
  logic logic_ev, cmp_ev, rot_ev, cma_ev, carry_only_ev, hold_ev, result_ev;
  assign logic_ev      = valid && dec.kind == K_GROUP && dec.sel[2] && dec.sel != OP_CMP;
  assign cmp_ev        = valid && dec.kind == K_GROUP && dec.sel == OP_CMP;
  assign rot_ev        = valid && dec.kind == K_ROT;
  assign cma_ev        = valid && dec.kind == K_CMA;
  assign carry_only_ev = valid && (dec.kind == K_STC || dec.kind == K_CMC);
  assign hold_ev       = !upd;
  assign result_ev     = valid && ((dec.kind == K_GROUP && dec.sel != OP_CMP) || dec.kind == K_DAA);

  // R6
  logic_clears_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    logic_ev |=> (flags_out[0] == 1'b0 && flags_out[2] == 1'b0));

  // R7
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ev |=> acc_out == $past(acc_in));

  // R9
  rot_only_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_ev |=> flags_out[4:1] == $past(flags_in[4:1]));

  // R11
  cma_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cma_ev |=> (flags_out == $past(flags_in) && acc_out == ~$past(acc_in)));

  // R12
  carry_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_only_ev |=> (acc_out == $past(acc_in) && flags_out[4:1] == $past(flags_in[4:1])));

  // R2 R13
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ev |=> ($stable(acc_out) && $stable(flags_out)));

  // R8
  szp_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_ev |=> (flags_out[3] == (acc_out == '0) && flags_out[1] == ~^acc_out
                   && flags_out[4] == acc_out[DW-1]));
endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       valid;
  logic [7:0] opcode;
  logic [7:0] acc_in;
  logic [7:0] operand;
  logic [4:0] flags_in;
  wire  [7:0] acc_out;
  wire  [4:0] flags_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] m_acc;
  logic [4:0] m_flg;

  acc_alu uut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode), .acc_in(acc_in),
    .operand(operand), .flags_in(flags_in), .acc_out(acc_out), .flags_out(flags_out)
  );

  function automatic logic even_ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2) == 0;
  endfunction

  function automatic logic [4:0] szp(input int r, input logic ac, input logic cy);
    int r8 = r % 256;
    return {r8 >= 128, r8 == 0, ac, even_ones(r8), cy};
  endfunction

  function automatic int pick(input int i);
    case (i)
      18: return 1;   19: return 8'h0F; 20: return 8'h10; 21: return 8'h7F;
      22: return 8'h80; 23: return 8'hFE; 24: return 8'h99; 25: return 8'h0A;
      default: return i * 15;
    endcase
  endfunction

  task automatic model(input logic [7:0] op, input int a, input int b, input logic [4:0] f);
    int c = f[0];
    int s;
    if (op[7:6] == 2'b10 || (op[7:6] == 2'b11 && op[2:0] == 3'b110)) begin
      case (op[5:3])
        3'd0, 3'd1: begin
          if (op[5:3] == 3'd0) c = 0;
          s = a + b + c;
          m_acc = 8'(s % 256);
          m_flg = szp(s, ((a % 16) + (b % 16) + c) > 15, s > 255);
        end
        3'd2, 3'd3, 3'd7: begin
          if (op[5:3] != 3'd3) c = 0;
          s = (a - b - c + 512) % 256;
          m_acc = (op[5:3] == 3'd7) ? 8'(a) : 8'(s);
          m_flg = szp(s, (a % 16) >= (b % 16) + c, a < b + c);
        end
        3'd4: begin m_acc = 8'(a & b); m_flg = szp(a & b, 0, 0); end
        3'd5: begin m_acc = 8'(a ^ b); m_flg = szp(a ^ b, 0, 0); end
        default: begin m_acc = 8'(a | b); m_flg = szp(a | b, 0, 0); end
      endcase
    end else if (op == 8'h07) begin
      m_acc = 8'((a * 2) % 256 + a / 128); m_flg = {f[4:1], a >= 128};
    end else if (op == 8'h0F) begin
      m_acc = 8'(a / 2 + (a % 2) * 128); m_flg = {f[4:1], (a % 2) == 1};
    end else if (op == 8'h17) begin
      m_acc = 8'((a * 2) % 256 + c); m_flg = {f[4:1], a >= 128};
    end else if (op == 8'h1F) begin
      m_acc = 8'(a / 2 + c * 128); m_flg = {f[4:1], (a % 2) == 1};
    end else if (op == 8'h27) begin
      int add = 0;
      int t;
      logic hi;
      if ((a % 16) > 9 || f[2]) add = 6;
      t = a + add;
      hi = f[0] || t >= 160;
      if (hi) t += 96;
      m_acc = 8'(t % 256);
      m_flg = szp(t, ((a % 16) + add) > 15, hi);
    end else if (op == 8'h2F) begin
      m_acc = 8'(255 - a); m_flg = f;
    end else if (op == 8'h37) begin
      m_acc = 8'(a); m_flg = {f[4:1], 1'b1};
    end else if (op == 8'h3F) begin
      m_acc = 8'(a); m_flg = {f[4:1], ~f[0]};
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if (acc_out !== m_acc || flags_out !== m_flg) begin
      errors++;
      $display("FAIL %s op=%h acc=%h flags=%b expected acc=%h flags=%b",
               tag, opcode, acc_out, flags_out, m_acc, m_flg);
    end
  endtask

  task automatic run(input logic [7:0] op, input int a, input int b, input logic [4:0] f,
                     input logic v, input string tag);
    @(negedge clk);
    opcode = op; acc_in = 8'(a); operand = 8'(b); flags_in = f; valid = v;
    @(negedge clk);
    valid = 1'b0;
    if (v) model(op, a, b, f);
    check(tag);
  endtask

  function automatic bit known(input logic [7:0] op);
    return op[7:6] == 2'b10 || (op[7:6] == 2'b11 && op[2:0] == 3'b110) ||
           (op[7:6] == 2'b00 && op[2:0] == 3'b111);
  endfunction

  initial begin
    rst_n = 1'b0; valid = 1'b0; opcode = '0; acc_in = '0; operand = '0; flags_in = '0;
    m_acc = '0; m_flg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset");

    // R3 R4 R5 R6 R7 R8: all sixteen group opcodes over a value grid
    for (int g = 0; g < 16; g++) begin
      for (int i = 0; i < 26; i++) begin
        for (int j = 0; j < 26; j++) begin
          for (int c = 0; c < 2; c++) begin
            logic [7:0] op;
            int a = pick(i);
            int b = pick(j);
            op = (g < 8) ? 8'(8'h80 | (g << 3) | ((i + j) % 8)) : 8'(8'hC6 | ((g - 8) << 3));
            run(op, a, b, {a[0], b[1], b[0], a[1], c[0]}, 1'b1,
                "R3 R4 R5 R6 R7 R8 group");
          end
        end
      end
    end

    // R9 rotates over every byte
    for (int r = 0; r < 4; r++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++)
          run(8'(8'h07 | (r << 3)), a, 0, {a[3], a[2], a[1], a[0], c[0]}, 1'b1, "R9 rotate");

    // R10 decimal adjust
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 4; k++)
        run(8'h27, a, 0, {a[7], a[0], k[1], a[2], k[0]}, 1'b1, "R10 decimal adjust");

    // R11 R12
    for (int a = 0; a < 256; a++) begin
      run(8'h2F, a, 255 - a, 5'(a), 1'b1, "R11 complement acc");
      run(8'h37, a, a, 5'(a >> 2), 1'b1, "R12 set carry");
      run(8'h3F, a, 0, 5'(a), 1'b1, "R12 complement carry");
    end

    // R2: valid low holds outputs
    run(8'h80, 8'h12, 8'h34, 5'h00, 1'b1, "R2 load");
    for (int k = 0; k < 8; k++)
      run(8'(8'h80 + k * 9), 8'hFF - k, 8'h11 * k, 5'(k), 1'b0, "R2 hold when not valid");

    // R13: unrecognised opcodes hold outputs
    run(8'h27, 8'h9B, 0, 5'h00, 1'b1, "R13 setup");
    for (int op = 0; op < 256; op++)
      if (!known(8'(op)))
        run(8'(op), 255 - op, op, 5'(op), 1'b1, "R13 ignored opcode");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired acc=%h flags=%b expected completion", acc_out, flags_out);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule